// File: doc/BRIEF.md
# Write-Once System Option Register

This block holds the system option bits of a microcontroller and drives the pin-function selects and signal routing that those bits control. A simple register port reaches two byte-wide option registers, and the port decodes nothing beyond its one address bit. The block takes two reset inputs: a power-on reset and a general reset. A power-on reset also counts as a general reset.

The pin register carries two write-once bits. One decides whether a shared pin acts as the debug/mode pin. The other decides whether a second shared pin acts as the external reset input; when that bit is set, the pin's internal pull-up is enabled. The routing register carries the watchdog clock-source bit, which is write-once. It also carries the SPI pin-location bit and the comparator-to-capture enables, and these are freely rewritable. Each register has its own lock state machine with two states. `LK_OPEN` is entered on any reset. The first accepted write to that register moves it to `LK_SEALED`, and it stays there until the next reset. Reads and idle cycles leave the state unchanged. Writes that arrive while a reset input is high are ignored.

Register map: address 0 (pin) has bit 1 as the debug-pin enable and bit 0 as the reset-pin enable. Address 1 (routing) has bit 7 as the watchdog clock select, bit 4 as the SPI location, and bits 1:0 as the comparator-to-capture enables. Every other bit position is unimplemented.

Top module: `sysopt_regs`

## Requirements
- R1: After power-on reset, address 0 reads 0x02 and address 1 reads 0x00. `dbg_pin_sel` is 1, `rst_pin_sel` and `rst_pin_pullup` are 0, `wdog_clk_bus` is 0, `spi_portb_pins` is 0x3C, `spi_porte_pins` is 0x00 and `cmp_cap_en` is 0.
- R2: The debug-pin enable (address 0 bit 1) takes the first write after a reset; later writes leave it unchanged. Any reset returns it to 1.
- R3: The reset-pin enable (address 0 bit 0) takes the first write after a reset; later writes leave it unchanged. A general reset without power-on reset keeps its value; only power-on reset clears it.
- R4: `rst_pin_pullup` is 1 exactly when the reset-pin enable is 1, and `rst_pin_sel` follows the same bit.
- R5: The watchdog clock select (address 1 bit 7, 1 = bus clock, 0 = internal 1 kHz clock) takes the first write after a reset and ignores later writes. Any reset returns it to 0.
- R6: The SPI location bit (address 1 bit 4) changes on every write to address 1. When it is 0, `spi_portb_pins` = 0x3C (port B pins 2..5) and `spi_porte_pins` = 0. When it is 1, `spi_porte_pins` = 0x0F (port E pins 0..3) and `spi_portb_pins` = 0. Any reset returns it to 0.
- R7: The comparator-to-capture enables (address 1 bits 1:0, bit n routes comparator n to channel 0 of timer n) change on every write to address 1 and drive `cmp_cap_en`. Any reset returns them to 0.
- R8: Unimplemented bit positions read as 0, and writes to them have no effect.
- R9: The first write to a register seals that register's write-once bits. Any reset unseals them again, so the next write is taken.
- R10: A write to the sealed routing register updates the SPI and comparator bits and leaves the watchdog bit unchanged.
- R11: Reads have no side effects: a register that has only been read still takes its first write.
- R12: Power-on reset alone clears every lock and restores every R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, synchronous |
| sys_rst | input | 1 | General reset, active high, synchronous |
| bus_addr | input | 1 | Register select: 0 = pin, 1 = routing |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dbg_pin_sel | output | 1 | 1: shared pin acts as debug/mode pin; 0: output-only alternates |
| rst_pin_sel | output | 1 | 1: shared pin acts as external reset; 0: input-only alternates |
| rst_pin_pullup | output | 1 | Pull-up enable for the reset-capable pin |
| wdog_clk_bus | output | 1 | Watchdog clock: 1 bus clock, 0 internal 1 kHz |
| spi_portb_pins | output | 8 | Port B pins carrying SPI signals |
| spi_porte_pins | output | 8 | Port E pins carrying SPI signals |
| cmp_cap_en | output | 2 | Comparator n output routed to timer n channel 0 |

## Verification
The hardest case to reach is a write-once value that has to survive a general reset while its lock is cleared. The reset-pin bit is written and sealed, and a second write is shown to be ignored. Then only the general reset is pulsed, and the bench confirms that the bit is still set while the register takes a fresh write. A final power-on reset follows a sealed routing register and a set reset-pin bit. This shows that power-on reset alone clears values and locks together, and that the registers accept writes again afterwards.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    localparam int REG_COUNT   = 2;
    localparam int ADDR_W      = 1;
    localparam int OPT_DW      = 8;

    localparam logic [ADDR_W-1:0] ADDR_PIN   = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE = 1'b1;

    localparam int PIN_DBG_BIT = 1;
    localparam int PIN_RST_BIT = 0;
    localparam int RT_WDOG_BIT = 7;
    localparam int RT_SPI_BIT  = 4;
endpackage

// File: rtl/sysopt_lock_fsm.sv
module sysopt_lock_fsm
    import sysopt_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic wr_hit,
    output logic sealed
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (clr) state_q <= LK_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_hit) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        sealed = (state_q == LK_SEALED);
    end

    AST_IDLE_KEEPS_OPEN: assert property (@(posedge clk) disable iff (clr)
        (state_q == LK_OPEN && !wr_hit) |=> (state_q == LK_OPEN)); // R11
    AST_WRITE_SEALS: assert property (@(posedge clk) disable iff (clr)
        wr_hit |=> sealed); // R9
endmodule

// File: rtl/sysopt_route_decode.sv
module sysopt_route_decode #(
    parameter int NUM_CMP    = 2,
    parameter int PORT_W     = 8,
    parameter int SPI_PINS   = 4,
    parameter int SPI_B_BASE = 2,
    parameter int SPI_E_BASE = 0
) (
    input  logic               dbg_en,
    input  logic               rst_en,
    input  logic               wdog_sel,
    input  logic               spi_alt,
    input  logic [NUM_CMP-1:0] cmp_en,
    output logic               dbg_pin_sel,
    output logic               rst_pin_sel,
    output logic               rst_pin_pullup,
    output logic               wdog_clk_bus,
    output logic [PORT_W-1:0]  spi_portb_pins,
    output logic [PORT_W-1:0]  spi_porte_pins,
    output logic [NUM_CMP-1:0] cmp_cap_en
);
    localparam logic [PORT_W-1:0] GROUP = PORT_W'((1 << SPI_PINS) - 1);
    localparam logic [PORT_W-1:0] MASK_B = GROUP << SPI_B_BASE;
    localparam logic [PORT_W-1:0] MASK_E = GROUP << SPI_E_BASE;

    always_comb begin
        dbg_pin_sel    = dbg_en;
        rst_pin_sel    = rst_en;
        rst_pin_pullup = rst_en;
        wdog_clk_bus   = wdog_sel;
        spi_portb_pins = spi_alt ? '0 : MASK_B;
        spi_porte_pins = spi_alt ? MASK_E : '0;
        cmp_cap_en     = cmp_en;
    end
endmodule

// File: rtl/sysopt_regs.sv
module sysopt_regs
    import sysopt_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int PORT_W  = 8
) (
    input  logic               clk,
    input  logic               por,
    input  logic               sys_rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [OPT_DW-1:0]  bus_wdata,
    output logic [OPT_DW-1:0]  bus_rdata,
    output logic               dbg_pin_sel,
    output logic               rst_pin_sel,
    output logic               rst_pin_pullup,
    output logic               wdog_clk_bus,
    output logic [PORT_W-1:0]  spi_portb_pins,
    output logic [PORT_W-1:0]  spi_porte_pins,
    output logic [NUM_CMP-1:0] cmp_cap_en
);
    localparam logic [OPT_DW-1:0] PIN_MASK =
        OPT_DW'((1 << PIN_DBG_BIT) | (1 << PIN_RST_BIT));
    localparam logic [OPT_DW-1:0] ROUTE_MASK =
        OPT_DW'((1 << RT_WDOG_BIT) | (1 << RT_SPI_BIT) | ((1 << NUM_CMP) - 1));

    logic                 gen_rst;
    logic [REG_COUNT-1:0] wr_hit;
    logic [REG_COUNT-1:0] sealed;

    logic               dbg_q;
    logic               rst_pin_q;
    logic               wdog_q;
    logic               spi_q;
    logic [NUM_CMP-1:0] cmp_q;

    assign gen_rst = por | sys_rst;

    always_comb begin
        for (int i = 0; i < REG_COUNT; i++) begin
            wr_hit[i] = bus_wr && !gen_rst && (bus_addr == ADDR_W'(i));
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : gen_lock
        sysopt_lock_fsm u_lock (
            .clk    (clk),
            .clr    (gen_rst),
            .wr_hit (wr_hit[g]),
            .sealed (sealed[g])
        );
    end

    // Reset-pin enable: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (por)
            rst_pin_q <= 1'b0;
        else if (wr_hit[ADDR_PIN] && !sealed[ADDR_PIN])
            rst_pin_q <= bus_wdata[PIN_RST_BIT];
    end

    // Debug-pin enable: set by every reset.
    always_ff @(posedge clk) begin
        if (gen_rst)
            dbg_q <= 1'b1;
        else if (wr_hit[ADDR_PIN] && !sealed[ADDR_PIN])
            dbg_q <= bus_wdata[PIN_DBG_BIT];
    end

    // Routing register: one write-once bit, the rest free.
    always_ff @(posedge clk) begin
        if (gen_rst) begin
            wdog_q <= 1'b0;
            spi_q  <= 1'b0;
            cmp_q  <= '0;
        end else if (wr_hit[ADDR_ROUTE]) begin
            if (!sealed[ADDR_ROUTE])
                wdog_q <= bus_wdata[RT_WDOG_BIT];
            spi_q <= bus_wdata[RT_SPI_BIT];
            cmp_q <= bus_wdata[NUM_CMP-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_PIN: begin
                bus_rdata[PIN_DBG_BIT] = dbg_q;
                bus_rdata[PIN_RST_BIT] = rst_pin_q;
            end
            ADDR_ROUTE: begin
                bus_rdata[RT_WDOG_BIT]  = wdog_q;
                bus_rdata[RT_SPI_BIT]   = spi_q;
                bus_rdata[NUM_CMP-1:0]  = cmp_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    sysopt_route_decode #(
        .NUM_CMP (NUM_CMP),
        .PORT_W  (PORT_W)
    ) u_decode (
        .dbg_en         (dbg_q),
        .rst_en         (rst_pin_q),
        .wdog_sel       (wdog_q),
        .spi_alt        (spi_q),
        .cmp_en         (cmp_q),
        .dbg_pin_sel    (dbg_pin_sel),
        .rst_pin_sel    (rst_pin_sel),
        .rst_pin_pullup (rst_pin_pullup),
        .wdog_clk_bus   (wdog_clk_bus),
        .spi_portb_pins (spi_portb_pins),
        .spi_porte_pins (spi_porte_pins),
        .cmp_cap_en     (cmp_cap_en)
    );

    AST_DBG_SEALED_HOLD: assert property (@(posedge clk) disable iff (gen_rst)
        (sealed[ADDR_PIN] && wr_hit[ADDR_PIN]) |=> $stable(dbg_pin_sel)); // R2
    AST_RSTPIN_SURVIVES: assert property (@(posedge clk) disable iff (por)
        sys_rst |=> $stable(rst_pin_sel)); // R3
    AST_WDOG_SEALED_HOLD: assert property (@(posedge clk) disable iff (gen_rst)
        (sealed[ADDR_ROUTE] && wr_hit[ADDR_ROUTE]) |=> $stable(wdog_clk_bus)); // R5
    AST_SPI_ONE_PORT: assert property (@(posedge clk) disable iff (gen_rst)
        $countones(spi_portb_pins | spi_porte_pins) == 4); // R6
    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (gen_rst)
        (bus_rdata & ~((bus_addr == ADDR_PIN) ? PIN_MASK : ROUTE_MASK)) == '0); // R8
    AST_POR_RESTORES: assert property (@(posedge clk)
        por |=> (dbg_pin_sel && !rst_pin_sel && !wdog_clk_bus && (cmp_cap_en == '0))); // R12
endmodule

// File: tb/sysopt_regs_tb.sv
module sysopt_regs_tb;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       sys_rst = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       dbg_pin_sel, rst_pin_sel, rst_pin_pullup, wdog_clk_bus;
    logic [7:0] spi_portb_pins, spi_porte_pins;
    logic [1:0] cmp_cap_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model of the requirements
    bit m_dbg, m_rst, m_wd, m_spi, m_lock0, m_lock1;
    bit [1:0] m_cmp;

    logic [29:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    sysopt_regs u_dut (
        .clk(clk), .por(por), .sys_rst(sys_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_pin_sel(dbg_pin_sel), .rst_pin_sel(rst_pin_sel),
        .rst_pin_pullup(rst_pin_pullup), .wdog_clk_bus(wdog_clk_bus),
        .spi_portb_pins(spi_portb_pins), .spi_porte_pins(spi_porte_pins),
        .cmp_cap_en(cmp_cap_en)
    );

    function automatic logic [29:0] expect_obs(bit a);
        logic [7:0] rd;
        rd = a ? {m_wd, 2'b00, m_spi, 2'b00, m_cmp} : {6'b0, m_dbg, m_rst};
        return {rd, m_dbg, m_rst, m_rst, m_wd,
                (m_spi ? 8'h00 : 8'h3C), (m_spi ? 8'h0F : 8'h00), m_cmp};
    endfunction

    task automatic check(bit a, string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = a;
        exp_q.push_back(expect_obs(a));
        tag_q.push_back(tag);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (!a) begin
            if (!m_lock0) begin m_dbg = d[1]; m_rst = d[0]; m_lock0 = 1; end
        end else begin
            if (!m_lock1) begin m_wd = d[7]; m_lock1 = 1; end
            m_spi = d[4]; m_cmp = d[1:0];
        end
    endtask

    task automatic pulse_reset(bit is_por);
        @(negedge clk);
        if (is_por) por = 1'b1; else sys_rst = 1'b1;
        @(negedge clk);
        por = 1'b0; sys_rst = 1'b0;
        if (is_por) m_rst = 0;
        m_dbg = 1; m_wd = 0; m_spi = 0; m_cmp = 0; m_lock0 = 0; m_lock1 = 0;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            logic [29:0] act, e;
            string t;
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {bus_rdata, dbg_pin_sel, rst_pin_sel, rst_pin_pullup,
                       wdog_clk_bus, spi_portb_pins, spi_porte_pins, cmp_cap_en};
                tests++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_dbg = 1; m_rst = 0; m_wd = 0; m_spi = 0; m_cmp = 0; m_lock0 = 0; m_lock1 = 0;
        repeat (2) @(negedge clk);
        por = 1'b0;
        check(0, "R1 pin reg after power-on");
        check(1, "R1 route reg after power-on");
        check(0, "R11 read only, first read");
        check(0, "R11 read only, second read");
        wr(0, 8'hFD);
        check(0, "R11 R2 R4 R8 first pin write taken");
        wr(0, 8'h02);
        check(0, "R2 R3 R9 second pin write ignored");
        pulse_reset(0);
        check(0, "R3 R2 R4 general reset keeps reset-pin bit");
        wr(0, 8'h00);
        check(0, "R9 pin reg writable after reset");
        wr(1, 8'hFF);
        check(1, "R5 R6 R7 R8 first route write");
        wr(1, 8'h00);
        check(1, "R10 R5 R6 R7 sealed route reg mixed write");
        wr(1, 8'h11);
        check(1, "R6 R7 free bits rewritten");
        pulse_reset(0);
        check(1, "R5 R6 R7 general reset clears route reg");
        check(0, "R2 general reset sets debug bit");
        wr(1, 8'h80);
        wr(0, 8'h01);
        check(1, "R9 route reg reopened after reset");
        check(0, "R4 reset pin with pull-up");
        pulse_reset(1);
        check(0, "R12 R3 power-on clears reset-pin bit");
        check(1, "R12 R1 power-on clears route reg");
        wr(0, 8'h01);
        wr(1, 8'h90);
        check(0, "R12 pin lock cleared by power-on");
        check(1, "R12 route lock cleared by power-on");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule